// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller With Refresh

This block drives a dynamic RAM whose cell array is square, 2048 rows by 2048 columns, with a 4-bit nibble at each column. A requester offers a 22-bit word address, a direction bit and write data. It holds that request until the controller pulses ready. The controller splits the address over 11 shared address pins. The upper half goes out as the row while the row strobe is low, and the lower half follows as the column under the column strobe. The write enable or the output enable then steers the nibble.

A free-running interval timer makes a refresh due at a fixed rate. The controller then performs a row-strobe-only cycle on the row named by an internal counter. That counter moves to the next row after each refresh and returns to row 0 after the last row. Refresh outranks new accesses. An access already under way always completes first. Each cycle is followed by a precharge gap in which both strobes stay high.

Top module: `mux_dram_ctrl`

## Requirements
- R1: While reset is held, and on leaving it, all four strobes are high (inactive), ready is low, the data drive enable is low and the refresh row counter is 0.
- R2: An access starts with the row strobe falling while the column strobe is high, with address bits [21:11] on the address pins. The address pins hold that row for exactly T_RCD cycles before the column strobe falls.
- R3: The column strobe stays low for exactly T_CAS cycles, with address bits [10:0] on the pins. It is never low while the row strobe is high, and it rises in the same cycle as the row strobe.
- R4: During the column phase of a write, write enable is low, output enable is high and the data pins are driven with the request nibble. During a read, output enable is low, write enable is high and the data pins are not driven. Outside the column phase both enables are high and nothing is driven.
- R5: Ready is high for exactly one cycle, the cycle right after the column phase ends. For a read, the data output holds the nibble stored at that address during that cycle.
- R6: After every row strobe rise, the row strobe stays high for at least T_RP cycles before it falls again.
- R7: A refresh holds the row strobe low for exactly T_REF cycles, with the column strobe, write enable and output enable all high.
- R8: The address pins during a refresh carry the refresh row. This row is 0 for the first refresh after reset, rises by one with each refresh and wraps from 2047 to 0.
- R9: The k-th refresh (k from 1) becomes due k×REF_INTERVAL cycles after reset release. With the controller idle, its row strobe falls in cycle k×REF_INTERVAL+1.
- R10: A refresh that falls due during an access starts one cycle after that access's precharge ends. No further access starts while a refresh is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write nibble |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read nibble, valid while ready is high |
| dram_addr | output | 11 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Data driven toward the memory |
| dram_dq_en | output | 1 | High while the controller drives the data pins |
| dram_dq_i | input | 4 | Data returned by the memory |

## Verification
The bench keeps the full 11-bit halves and shortens only the timing: T_RCD=2, T_CAS=2, T_RP=2, T_REF=3 and REF_INTERVAL=24. With a 24-cycle interval, the refresh row counter goes through all 2048 rows and wraps within about fifty thousand cycles, so the wrap check is made at the real row count. An access lasts 7 cycles, so a dense request stream makes refreshes fall due in every phase of an access. This lets the bench check the exact deferred start times against its own model of the timer.

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl #(
  parameter int HALF_W       = 11,
  parameter int DQ_W         = 4,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_REF        = 3,
  parameter int REF_INTERVAL = 1563
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic [DQ_W-1:0]     req_wdata,
  output logic                req_ready,
  output logic [DQ_W-1:0]     rsp_rdata,
  output logic [HALF_W-1:0]   dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [DQ_W-1:0]     dram_dq_o,
  output logic                dram_dq_en,
  input  logic [DQ_W-1:0]     dram_dq_i
);
  localparam int TMAX  = (T_RCD > T_CAS ? T_RCD : T_CAS) > (T_RP > T_REF ? T_RP : T_REF)
                       ? (T_RCD > T_CAS ? T_RCD : T_CAS) : (T_RP > T_REF ? T_RP : T_REF);
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int TMR_W = $clog2(REF_INTERVAL);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_REF, S_PRE} state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [TMR_W-1:0]    tmr;
  logic                ref_due;
  logic [HALF_W-1:0]   ref_row;
  logic [HALF_W-1:0]   a_row, a_col;
  logic                a_wr;
  logic [DQ_W-1:0]     a_wdata;
  logic                ref_take;
  logic                last;

  assign ref_take = (state == S_IDLE) && ref_due;
  assign last     = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      tmr       <= TMR_W'(REF_INTERVAL - 1);
      ref_due   <= 1'b0;
      ref_row   <= '0;
      a_row     <= '0;
      a_col     <= '0;
      a_wr      <= 1'b0;
      a_wdata   <= '0;
      rsp_rdata <= '0;
      req_ready <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      tmr       <= (tmr == '0) ? TMR_W'(REF_INTERVAL - 1) : tmr - 1'b1;
      ref_due   <= (tmr == '0) || (ref_due && !ref_take);
      case (state)
        S_IDLE:
          if (ref_due) begin
            state <= S_REF;
            cnt   <= CNT_W'(T_REF - 1);
          end else if (req_valid) begin
            state   <= S_ROW;
            cnt     <= CNT_W'(T_RCD - 1);
            a_row   <= req_addr[2*HALF_W-1:HALF_W];
            a_col   <= req_addr[HALF_W-1:0];
            a_wr    <= req_write;
            a_wdata <= req_wdata;
          end
        S_ROW:
          if (last) begin
            state <= S_COL;
            cnt   <= CNT_W'(T_CAS - 1);
          end else cnt <= cnt - 1'b1;
        S_COL:
          if (last) begin
            state     <= S_PRE;
            cnt       <= CNT_W'(T_RP - 1);
            req_ready <= 1'b1;
            if (!a_wr) rsp_rdata <= dram_dq_i;
          end else cnt <= cnt - 1'b1;
        S_REF:
          if (last) begin
            state   <= S_PRE;
            cnt     <= CNT_W'(T_RP - 1);
            ref_row <= ref_row + 1'b1;
          end else cnt <= cnt - 1'b1;
        S_PRE:
          if (last) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dram_ras_n = !(state == S_ROW || state == S_COL || state == S_REF);
  assign dram_cas_n = (state != S_COL);
  assign dram_we_n  = !(state == S_COL && a_wr);
  assign dram_oe_n  = !(state == S_COL && !a_wr);
  assign dram_dq_en = (state == S_COL) && a_wr;
  assign dram_dq_o  = a_wdata;
  assign dram_addr  = (state == S_REF) ? ref_row : (state == S_COL) ? a_col : a_row;
endmodule

// File: rtl/mux_dram_ctrl_chk.sv
module mux_dram_ctrl_chk #(
  parameter int HALF_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_en,
  input logic              ready,
  input logic [HALF_W-1:0] addr
);
  // R3
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  // R3
  strobes_release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n));

  // R4
  enables_in_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n || dq_en) |-> (!cas_n && (we_n != oe_n) && (dq_en == !we_n)));

  // R5
  ready_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R5
  ready_after_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> ready);

  // R6
  precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  // R2
  row_address_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n) && cas_n && $past(cas_n)) |-> $stable(addr));
endmodule

bind mux_dram_ctrl mux_dram_ctrl_chk #(.HALF_W(HALF_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ras_n (dram_ras_n),
  .cas_n (dram_cas_n),
  .we_n  (dram_we_n),
  .oe_n  (dram_oe_n),
  .dq_en (dram_dq_en),
  .ready (req_ready),
  .addr  (dram_addr)
);

// File: tb/mux_dram_ctrl_tb.sv
`timescale 1ns/1ps
module mux_dram_ctrl_tb;
  localparam int HW = 11;
  localparam int RCD = 2, CASW = 2, RP = 2, REFW = 3, IVL = 24;
  localparam int ACC = RCD + CASW + RP + 1;
  localparam int ROWS = 1 << HW;

  typedef struct { bit w; logic [2*HW-1:0] a; logic [3:0] d; } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [2*HW-1:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready;
  logic [3:0] rsp_rdata;
  logic [HW-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_en;
  logic [3:0] dram_dq_o;
  logic [3:0] dram_dq_i = '0;

  always #5 clk = ~clk;

  mux_dram_ctrl #(.HALF_W(HW), .DQ_W(4), .T_RCD(RCD), .T_CAS(CASW), .T_RP(RP),
                  .T_REF(REFW), .REF_INTERVAL(IVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_o(dram_dq_o), .dram_dq_en(dram_dq_en), .dram_dq_i(dram_dq_i));

  int checks = 0, errors = 0;
  bit done = 0;
  item_t pin_q[$];
  item_t rsp_q[$];
  logic [3:0] shadow [int];
  logic [3:0] cells [int];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_req(bit w, logic [2*HW-1:0] a, logic [3:0] d);
    item_t it;
    it.w = w; it.a = a;
    if (w) begin
      it.d = d;
      shadow[int'(a)] = d;
    end else it.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0;
    pin_q.push_back(it);
    rsp_q.push_back(it);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    req_valid = 0;
  endtask

  // pin-level memory model and monitors
  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  bit prev_ras = 1, prev_cas = 1, prev_rdy = 0, is_acc = 0;
  int ras_fall = 0, cas_fall = 0, high_cnt = 100, ref_served = 0;
  int last_acc = -1000;
  logic [HW-1:0] cur_row = '0, cur_col = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_rdy) check(!req_ready, "R5 ready width", req_ready, 0);
      if (req_ready) begin
        item_t e;
        if (rsp_q.size() == 0) check(0, "R5 unexpected ready", 1, 0);
        else begin
          e = rsp_q.pop_front();
          if (!e.w) check(rsp_rdata == e.d, "R5 read data", rsp_rdata, e.d);
        end
      end
      if (!dram_ras_n && dram_cas_n && !(dram_we_n && dram_oe_n && !dram_dq_en))
        check(0, "R7/R4 enables outside column", {dram_we_n, dram_oe_n, dram_dq_en}, 3'b110);
      if (prev_ras && !dram_ras_n) begin
        check(high_cnt >= RP, "R6 precharge", high_cnt, RP);
        ras_fall = cyc; cur_row = dram_addr; is_acc = 0;
      end
      if (prev_cas && !dram_cas_n) begin
        item_t e;
        is_acc = 1; cas_fall = cyc; cur_col = dram_addr;
        check(cyc - ras_fall == RCD, "R2 row phase length", cyc - ras_fall, RCD);
        check(ras_fall < (ref_served + 1) * IVL + 1, "R10 access while refresh due",
              ras_fall, (ref_served + 1) * IVL + 1);
        last_acc = ras_fall;
        if (pin_q.size() == 0) check(0, "R2 unexpected access", 1, 0);
        else begin
          e = pin_q.pop_front();
          check(cur_row == e.a[2*HW-1:HW], "R2 row address", cur_row, e.a[2*HW-1:HW]);
          check(cur_col == e.a[HW-1:0], "R3 column address", cur_col, e.a[HW-1:0]);
          if (e.w) check(!dram_we_n && dram_oe_n && dram_dq_en && dram_dq_o == e.d,
                         "R4 write pins", {dram_we_n, dram_oe_n, dram_dq_en, dram_dq_o},
                         {3'b011, e.d});
          else check(dram_we_n && !dram_oe_n && !dram_dq_en, "R4 read pins",
                     {dram_we_n, dram_oe_n, dram_dq_en}, 3'b100);
        end
      end
      if (!dram_cas_n && !dram_we_n && dram_dq_en) cells[int'({cur_row, cur_col})] = dram_dq_o;
      dram_dq_i <= (!dram_cas_n && !dram_oe_n && cells.exists(int'({cur_row, cur_col})))
                   ? cells[int'({cur_row, cur_col})] : 4'h0;
      if (!prev_cas && dram_cas_n) begin
        check(cyc - cas_fall == CASW, "R3 column width", cyc - cas_fall, CASW);
        check(dram_ras_n, "R3 strobes release together", dram_ras_n, 1);
      end
      if (!prev_ras && dram_ras_n && !is_acc) begin
        int due, exp_fall;
        due = (ref_served + 1) * IVL + 1;
        exp_fall = (last_acc + ACC > due) ? last_acc + ACC : due;
        check(cyc - ras_fall == REFW, "R7 refresh width", cyc - ras_fall, REFW);
        check(cur_row == HW'(ref_served % ROWS),
              (ref_served == ROWS) ? "R8 refresh row wrap" : "R8 refresh row",
              cur_row, ref_served % ROWS);
        check(ras_fall == exp_fall, (exp_fall == due) ? "R9 refresh timing" : "R10 deferred refresh",
              ras_fall, exp_fall);
        ref_served++;
      end
      high_cnt = dram_ras_n ? high_cnt + 1 : 0;
      prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_rdy = req_ready;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!req_ready && !dram_dq_en, "R1 ready/drive in reset", {req_ready, dram_dq_en}, 0);
    rst_n = 1;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && !req_ready, "R1 after release",
          {dram_ras_n, dram_cas_n, req_ready}, 3'b110);
    do_req(1, 22'h000000, 4'h5);
    do_req(1, 22'h3FFFFF, 4'hA);
    do_req(1, 22'h3FF800, 4'h3);
    do_req(1, 22'h0007FF, 4'hC);
    do_req(0, 22'h000000, 4'h0);
    do_req(0, 22'h3FFFFF, 4'h0);
    do_req(0, 22'h3FF800, 4'h0);
    do_req(0, 22'h0007FF, 4'h0);
    do_req(0, 22'h155555, 4'h0);
    do_req(1, 22'h000000, 4'h9);
    do_req(0, 22'h000000, 4'h0);
    repeat (5 * IVL) @(negedge clk);
    x = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      do_req(x[31], {x[20:16], 6'd0, x[10:6], 6'd0}, x[3:0]);
      if (x[30:29] == 2'b00) repeat (int'(x[28:25])) @(negedge clk);
    end
    while (ref_served < ROWS + 2) @(negedge clk);
    do_req(0, 22'h3FFFFF, 4'h0);
    repeat (10) @(negedge clk);
    check(pin_q.size() == 0 && rsp_q.size() == 0, "R5 all responses seen",
          pin_q.size() + rsp_q.size(), 0);
    finish_run();
  end
endmodule